// File: doc/BRIEF.md
# Processor Tick Timer

This block is a system-tick timer for a processor core. It holds a counter register and a control register. The control register packs a match period, an interrupt-enable bit, a sticky interrupt-pending bit and a 2-bit mode. An external strobe, `tick_en`, stands in for a fixed 20 MHz timebase. On every cycle where the strobe is high and the timer is running, the counter steps forward by one.

A match is detected on a running tick when the low `PER_W` bits of the counter equal the period field. The counter's upper bits play no part in the compare. A counter whose low field is already past the period therefore has to wrap that field through zero before it matches again. On a match, the pending bit is set if interrupts are enabled, and the mode then decides what the counter does next:
- **off:** never counts.
- **restart:** reloads zero.
- **one-shot:** freezes.
- **continuous:** keeps counting through the wrap.

Software writes either register through a single write port. Both registers are always visible on output ports.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter output, the control output and `irq_o` are all zero.
- R2: A write with `wr_sel`=0 loads the counter and a write with `wr_sel`=1 loads the control register. The value is visible on `count_o`/`mode_o` in the next cycle. A write cycle ignores that cycle's tick, so no increment and no match happen.
- R3: In mode 00 (off), the counter never advances and no match occurs, whatever `tick_en` does.
- R4: Control register layout: period in bits [PER_W-1:0] (27:0 by default), pending at bit PER_W (28), enable at bit PER_W+1 (29), mode in bits [PER_W+3:PER_W+2] (31:30). A match is a tick on a running counter whose bits [PER_W-1:0] equal the period. Higher counter bits are ignored, so a counter whose low field is past the period matches only after that field wraps.
- R5: On a match with enable=1, the pending bit becomes 1 in the next cycle. With enable=0, a match leaves pending unchanged.
- R6: Pending stays set until software writes it to 0, and a write may also set it. `irq_o` is high exactly when pending and enable are both 1.
- R7: In mode 01 (restart), a match loads zero into the counter, and counting goes on from there.
- R8: In mode 10 (one-shot), a match holds the counter at its value and stops further ticks. Counting resumes only after a write to either register.
- R9: In mode 11 (continuous), a match increments the counter as usual, and the counter wraps from all ones to zero.
- R10: A cycle with `tick_en` low and no write changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase strobe, one per counting period |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 control |
| wr_data | input | DATA_W (32) | Write data |
| count_o | output | CNT_W (32) | Counter register |
| mode_o | output | PER_W+4 (32) | Control register |
| irq_o | output | 1 | Timer interrupt request |

## Verification
The hardest case to reach from the ports is a match on a counter whose low field starts above the period while its upper bits are non-zero. A matching full-width value would never come up in that case, so the match has to come from the masked compare after a wrap of the low field. The bench uses a small configuration (8-bit counter, 4-bit period) so that it can preload such counters and sweep every period, every mode and both enable settings. It drives an irregular tick pattern from a shift register and compares every cycle against an arithmetic model. Directed sequences pin down the one-shot freeze and its release by a write, the sticky pending bit, and the case where a write and a tick land in the same cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   typedef enum logic [1:0] {
      TT_OFF     = 2'b00,
      TT_RESTART = 2'b01,
      TT_ONESHOT = 2'b10,
      TT_FREE    = 2'b11
   } tt_mode_e;
endpackage

// File: rtl/ttmr_match.sv
module ttmr_match #(
   parameter int PER_W = 28
) (
   input  logic [PER_W-1:0] low_cnt,
   input  logic [PER_W-1:0] period,
   output logic             eq
);
   assign eq = (low_cnt == period);
endmodule

// File: rtl/ttmr_counter.sv
module ttmr_counter
   import tick_timer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clr_halt,
   input  logic             run,
   input  logic             hit,
   input  tt_mode_e         mode,
   output logic [CNT_W-1:0] count,
   output logic             halted
);
   logic [CNT_W-1:0] count_q, count_d;
   logic             halt_q;

   always_comb begin
      count_d = count_q;
      if (load)
         count_d = load_val;
      else if (run) begin
         if (hit && mode == TT_RESTART)
            count_d = '0;
         else if (hit && mode == TT_ONESHOT)
            count_d = count_q;
         else
            count_d = count_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         halt_q  <= 1'b0;
      end else begin
         count_q <= count_d;
         if (clr_halt)
            halt_q <= 1'b0;
         else if (run && hit && mode == TT_ONESHOT)
            halt_q <= 1'b1;
      end
   end

   assign count  = count_q;
   assign halted = halt_q;

   // R1: counter leaves reset at zero
   assert_cnt_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (count_q == '0));
   // R2: a load lands in the next cycle
   assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count_q == $past(load_val)));
endmodule

// File: rtl/ttmr_ctrl.sv
module ttmr_ctrl
   import tick_timer_pkg::*;
#(
   parameter int PER_W = 28,
   localparam int MODE_W = PER_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MODE_W-1:0] load_val,
   input  logic              hit,
   output logic [PER_W-1:0]  period,
   output logic              pend,
   output logic              ie,
   output tt_mode_e          mode
);
   logic [PER_W-1:0] period_q;
   logic             pend_q, ie_q;
   tt_mode_e         mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_q <= '0;
         pend_q   <= 1'b0;
         ie_q     <= 1'b0;
         mode_q   <= TT_OFF;
      end else if (load) begin
         period_q <= load_val[PER_W-1:0];
         pend_q   <= load_val[PER_W];
         ie_q     <= load_val[PER_W+1];
         mode_q   <= tt_mode_e'(load_val[PER_W+3:PER_W+2]);
      end else if (hit && ie_q) begin
         pend_q   <= 1'b1;
      end
   end

   assign period = period_q;
   assign pend   = pend_q;
   assign ie     = ie_q;
   assign mode   = mode_q;

   // R5: enabled match sets pending
   assert_pend_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ie_q && !load) |=> pend_q);
   // R5: with enable clear a match leaves pending low
   assert_pend_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_q && !pend_q && !load) |=> !pend_q);
   // R6: pending is sticky without a write
   assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !load) |=> pend_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int PER_W  = 28,
   parameter int DATA_W = (CNT_W > PER_W + 4) ? CNT_W : PER_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count_o,
   output logic [PER_W+3:0]  mode_o,
   output logic              irq_o
);
   localparam int MODE_W = PER_W + 4;

   generate
      if (PER_W < 1 || PER_W > CNT_W) begin : g_bad_per
         $error("tick_timer: PER_W must lie in 1..CNT_W");
      end
      if (DATA_W < CNT_W || DATA_W < MODE_W) begin : g_bad_data
         $error("tick_timer: DATA_W too narrow for a register");
      end
   endgenerate

   logic             cnt_wr, mode_wr, run, eq, hit, halted;
   logic             pend, ie;
   logic [PER_W-1:0] period;
   tt_mode_e         mode;
   logic [CNT_W-1:0] count;

   assign cnt_wr  = wr_en & ~wr_sel;
   assign mode_wr = wr_en &  wr_sel;
   assign run     = tick_en & ~wr_en & (mode != TT_OFF) & ~halted;
   assign hit     = run & eq;

   ttmr_match #(.PER_W(PER_W)) u_match (
      .low_cnt (count[PER_W-1:0]),
      .period  (period),
      .eq      (eq)
   );

   ttmr_counter #(.CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_wr),
      .load_val (wr_data[CNT_W-1:0]),
      .clr_halt (wr_en),
      .run      (run),
      .hit      (hit),
      .mode     (mode),
      .count    (count),
      .halted   (halted)
   );

   ttmr_ctrl #(.PER_W(PER_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (mode_wr),
      .load_val (wr_data[MODE_W-1:0]),
      .hit      (hit),
      .period   (period),
      .pend     (pend),
      .ie       (ie),
      .mode     (mode)
   );

   assign count_o = count;
   assign mode_o  = {mode, ie, pend, period};
   assign irq_o   = pend & ie;

   // R3: off mode never moves the counter
   assert_off_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && mode == TT_OFF) |=> (count_o == $past(count_o)));
   // R7: restart match reloads zero
   assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode == TT_RESTART) |=> (count_o == '0));
   // R8: a frozen one-shot counter stays put until a write
   assert_oneshot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !wr_en) |=> $stable(count_o));
   // R9: continuous match steps on by one
   assert_free_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode == TT_FREE) |=> (count_o == $past(count_o) + CNT_W'(1)));
   // R10: no tick and no write leaves both registers alone
   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_en) |=> ($stable(count_o) && $stable(mode_o)));
endmodule

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
   localparam int CW = 8;
   localparam int PW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_sel = 1'b0;
   logic [7:0]    wr_data = '0;
   logic [CW-1:0] count_o;
   logic [PW+3:0] mode_o;
   logic          irq_o;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] m_cnt = '0;
   logic [7:0] m_mode = '0;
   logic       m_halt = 1'b0;

   always #2.5 clk = ~clk;

   tick_timer #(.CNT_W(CW), .PER_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data),
      .count_o(count_o), .mode_o(mode_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // arithmetic model of the requirements, advanced once per clock
   task automatic model(input logic t, input logic w, input logic s, input logic [7:0] d);
      if (w) begin
         if (s) m_mode = d; else m_cnt = d;
         m_halt = 1'b0;
      end else if (t && m_mode[7:6] != 2'b00 && !m_halt) begin
         if (m_cnt[3:0] == m_mode[3:0]) begin
            if (m_mode[5]) m_mode[4] = 1'b1;
            case (m_mode[7:6])
               2'b01:   m_cnt = 8'h00;
               2'b10:   m_halt = 1'b1;
               default: m_cnt = m_cnt + 8'h01;
            endcase
         end else
            m_cnt = m_cnt + 8'h01;
      end
   endtask

   task automatic cyc(input logic t, input logic w, input logic s, input logic [7:0] d);
      @(negedge clk);
      tick_en = t; wr_en = w; wr_sel = s; wr_data = d;
      @(posedge clk);
      model(t, w, s, d);
      #1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic cmp_all(input string tag);
      n_chk++;
      if (count_o !== m_cnt || mode_o !== m_mode || irq_o !== (m_mode[4] & m_mode[5])) begin
         n_fail++;
         $display("FAIL %s actual=%h/%h/%b expected=%h/%h/%b", tag, count_o, mode_o,
                  irq_o, m_cnt, m_mode, m_mode[4] & m_mode[5]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] lf;
      lf = 8'hA5;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      chk("R1 count", count_o, 8'h00);
      chk("R1 mode", mode_o, 8'h00);
      chk("R1 irq", {7'd0, irq_o}, 8'h00);
      // R3 off mode ignores ticks
      ticks(5);
      chk("R3 off no advance", count_o, 8'h00);
      // R2 writes, a mode write with a tick drops the tick
      cyc(1'b0, 1'b1, 1'b0, 8'h5A);
      chk("R2 counter write", count_o, 8'h5A);
      cyc(1'b1, 1'b1, 1'b1, 8'hEF);
      chk("R2 mode write", mode_o, 8'hEF);
      chk("R2 tick dropped on write", count_o, 8'h5A);
      // R10 idle cycles
      repeat (3) cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R10 idle count", count_o, 8'h5A);
      chk("R10 idle mode", mode_o, 8'hEF);
      // R4 masked match after wrap of the low field
      cyc(1'b0, 1'b1, 1'b0, 8'h25);
      cyc(1'b0, 1'b1, 1'b1, 8'hE3);
      ticks(14);
      chk("R4 before match count", count_o, 8'h33);
      chk("R4 no early pending", mode_o, 8'hE3);
      ticks(1);
      chk("R4 match count", count_o, 8'h34);
      chk("R5 pending set", mode_o, 8'hF3);
      chk("R6 irq high", {7'd0, irq_o}, 8'h01);
      // R6 pending sticky, irq gated by enable
      cyc(1'b0, 1'b1, 1'b1, 8'hD3);
      chk("R6 irq masked", {7'd0, irq_o}, 8'h00);
      ticks(20);
      chk("R6 pending kept", mode_o, 8'hD3);
      cyc(1'b0, 1'b1, 1'b1, 8'hC3);
      ticks(20);
      chk("R5 no pending when disabled", mode_o, 8'hC3);
      // R7 restart
      cyc(1'b0, 1'b1, 1'b0, 8'h00);
      cyc(1'b0, 1'b1, 1'b1, 8'h45);
      ticks(5);
      chk("R7 reach period", count_o, 8'h05);
      ticks(1);
      chk("R7 reload zero", count_o, 8'h00);
      ticks(6);
      chk("R7 second reload", count_o, 8'h00);
      // R8 one-shot
      cyc(1'b0, 1'b1, 1'b0, 8'hF0);
      cyc(1'b0, 1'b1, 1'b1, 8'hA2);
      ticks(3);
      chk("R8 frozen value", count_o, 8'hF2);
      chk("R8 pending", mode_o, 8'hB2);
      ticks(10);
      chk("R8 stays frozen", count_o, 8'hF2);
      cyc(1'b0, 1'b1, 1'b0, 8'h10);
      ticks(1);
      chk("R8 resumes after write", count_o, 8'h11);
      // R9 continuous wrap
      cyc(1'b0, 1'b1, 1'b0, 8'hFE);
      cyc(1'b0, 1'b1, 1'b1, 8'hCF);
      ticks(2);
      chk("R9 wrap through match", count_o, 8'h00);
      ticks(1);
      chk("R9 keeps counting", count_o, 8'h01);
      // R2 counter write beats a tick
      cyc(1'b1, 1'b1, 1'b0, 8'h80);
      chk("R2 write over tick", count_o, 8'h80);
      // sweep: every mode, enable and period, irregular ticks
      for (int md = 0; md < 4; md++) begin
         for (int en = 0; en < 2; en++) begin
            for (int per = 0; per < 16; per++) begin
               string tag;
               case (md)
                  0: tag = "R3 sweep";
                  1: tag = "R7 sweep";
                  2: tag = "R8 sweep";
                  default: tag = "R9 sweep";
               endcase
               cyc(1'b0, 1'b1, 1'b0, 8'(per * 7 + md * 29 + 3));
               cyc(1'b0, 1'b1, 1'b1, {md[1:0], en[0], 1'b0, per[3:0]});
               cmp_all(tag);
               for (int k = 0; k < 40; k++) begin
                  lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                  cyc(lf[0] | lf[1], 1'b0, 1'b0, 8'h00);
                  cmp_all(tag);
               end
            end
         end
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule